// File: doc/BRIEF.md
# Square tile transpose buffer

This block turns a stream of matrix rows into a stream of matrix columns, one square tile of TILE by TILE words at a time (16 by 16 words of 32 bits by default). A tile enters as TILE row beats, each carrying one full row of TILE words. The block then switches phase and emits the same tile as TILE beats, where beat k carries column k of the input tile. Loading and draining are strictly separated: no column leaves before the whole tile has arrived, and no new row is taken while a tile is draining.

The words sit in a scratch store of TILE banks whose logical row stride is TILE+1 words. Because of that one-word pad, the TILE words of any input row and the TILE words of any column each land in TILE different banks. Every beat, in either direction, therefore costs exactly one access per bank. Partial tiles at the right and bottom edges of a matrix are handled by bounds taken with the first row of each tile. Out-of-range words are not stored. On the output they appear as zero, with their lane-valid bit cleared.

Top module: `tile_transposer`

## Requirements
- R1: A synchronous reset, asserted at any point, leaves the block in the load phase with an empty tile: in_ready is 1 and out_valid is 0 on the next cycle.
- R2: In the load phase in_ready is 1, and each cycle with in_valid and in_ready stores one row. Rows are numbered 0 to TILE-1 in arrival order. After exactly TILE accepted rows, in_ready drops to 0 and out_valid rises to 1.
- R3: During the drain, beat k (k = 0 to TILE-1) carries in lane j, bits [j*DW +: DW] of out_row, the word that arrived in lane k of input row j.
- R4: A drain beat is consumed only on a cycle with out_valid and out_ready. While out_ready is 0, out_row, out_lane_ok and out_last hold their values.
- R5: out_last is 1 on the TILE-th drain beat and on no other cycle.
- R6: While out_valid is 1, in_ready is 0, and input beats presented then have no effect on the tile being drained. The cycle after the last drain beat is consumed, in_ready is 1 and out_valid is 0.
- R7: mat_width, mat_height, tile_col0 and tile_row0 are sampled on the first accepted row of a tile. Output lane j of beat k is valid when tile_row0 + j < mat_height and tile_col0 + k < mat_width, with the sums taken without overflow. Invalid lanes read zero and have their bit in out_lane_ok cleared.
- R8: Changes to the bound inputs after the first row of a tile has been accepted do not affect that tile.
- R9: Tiles can follow one another back to back. Masked words of one tile never reveal data left over from an earlier tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block accepts an input row (load phase) |
| in_row | input | TILE*DW | One tile row; lane c in bits [c*DW +: DW] |
| mat_width | input | DIMW | Matrix column count, sampled with row 0 |
| mat_height | input | DIMW | Matrix row count, sampled with row 0 |
| tile_col0 | input | DIMW | Matrix column of the tile's first column |
| tile_row0 | input | DIMW | Matrix row of the tile's first row |
| out_valid | output | 1 | Output column present (drain phase) |
| out_ready | input | 1 | Consumer takes the output column |
| out_row | output | TILE*DW | One tile column; lane j holds input row j |
| out_lane_ok | output | TILE | Per-lane valid bits after edge masking |
| out_last | output | 1 | Final beat of the tile |

## Verification
The hardest case to reach from the ports is the bound comparison at the very top of the coordinate range. There, tile_col0 + k or tile_row0 + j would wrap a DIMW-bit sum. The bench places one tile with its origin a few words below the largest coordinate, so that only a wider comparison gives the right lane mask. Other tiles drive zero bounds, and bounds that cut off part of the columns and part of the rows. The bound inputs are changed in the middle of every load, and the bench pushes rows while the drain is running and adds random-looking gaps on both handshakes. One load is also cut short by a reset.

// File: rtl/tile_transposer.sv
module tile_transposer #(
  parameter int TILE = 16,
  parameter int DW   = 32,
  parameter int DIMW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TILE*DW-1:0]   in_row,
  input  logic [DIMW-1:0]      mat_width,
  input  logic [DIMW-1:0]      mat_height,
  input  logic [DIMW-1:0]      tile_col0,
  input  logic [DIMW-1:0]      tile_row0,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [TILE*DW-1:0]   out_row,
  output logic [TILE-1:0]      out_lane_ok,
  output logic                 out_last
);
  localparam int STRIDE = TILE + 1;
  localparam int DEPTH  = (TILE * STRIDE + TILE - 1) / TILE;
  localparam int IW     = $clog2(TILE);
  localparam int AW     = $clog2(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(TILE - 1);

  logic          draining;
  logic [IW-1:0] cnt;
  logic [DIMW-1:0] w_q, h_q, c0_q, r0_q;
  logic [DW-1:0] bank_mem [TILE][DEPTH];

  function automatic logic fits(input logic [DIMW-1:0] base,
                                input logic [IW-1:0] off,
                                input logic [DIMW-1:0] lim);
    return ({1'b0, base} + (DIMW+1)'(off)) < {1'b0, lim};
  endfunction

  assign in_ready  = !draining;
  assign out_valid = draining;
  assign out_last  = draining && (cnt == LAST);

  wire accept = in_valid && in_ready;
  wire pop    = out_valid && out_ready;
  wire first  = (cnt == '0);

  wire [DIMW-1:0] w_eff  = first ? mat_width  : w_q;
  wire [DIMW-1:0] h_eff  = first ? mat_height : h_q;
  wire [DIMW-1:0] c0_eff = first ? tile_col0  : c0_q;
  wire [DIMW-1:0] r0_eff = first ? tile_row0  : r0_q;
  wire row_in = fits(r0_eff, cnt, h_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      cnt      <= '0;
      w_q      <= '0;
      h_q      <= '0;
      c0_q     <= '0;
      r0_q     <= '0;
    end else if (accept) begin
      if (first) begin
        w_q  <= mat_width;
        h_q  <= mat_height;
        c0_q <= tile_col0;
        r0_q <= tile_row0;
      end
      if (cnt == LAST) begin
        draining <= 1'b1;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (pop) begin
      if (cnt == LAST) draining <= 1'b0;
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  for (genvar b = 0; b < TILE; b++) begin : g_bank
    logic [IW-1:0] lane;
    logic [AW-1:0] idx;
    logic          we;
    always_comb begin
      lane = IW'(b) - cnt;
      idx  = AW'((int'(cnt) * STRIDE + int'(lane)) / TILE);
      we   = accept && row_in && fits(c0_eff, lane, w_eff);
    end
    always_ff @(posedge clk) begin
      if (we) bank_mem[b][idx] <= in_row[int'(lane)*DW +: DW];
    end
  end

  wire col_in = fits(c0_q, cnt, w_q);

  always_comb begin
    for (int j = 0; j < TILE; j++) begin
      logic [IW-1:0] rb;
      logic [AW-1:0] ri;
      logic          ok;
      rb = IW'(j) + cnt;
      ri = AW'((j * STRIDE + int'(cnt)) / TILE);
      ok = draining && col_in && fits(r0_q, IW'(j), h_q);
      out_lane_ok[j]       = ok;
      out_row[j*DW +: DW]  = ok ? bank_mem[rb][ri] : '0;
    end
  end
endmodule

// File: rtl/tile_transposer_chk.sv
module tile_transposer_chk #(
  parameter int TILE = 16,
  parameter int DW   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [TILE*DW-1:0] out_row,
  input logic [TILE-1:0]    out_lane_ok,
  input logic               out_last
);
  localparam int CW = $clog2(TILE + 1);
  logic [CW-1:0] ld_cnt, dr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt <= '0;
      dr_cnt <= '0;
    end else begin
      if (in_valid && in_ready) ld_cnt <= ld_cnt + 1'b1;
      if (out_valid && out_ready) begin
        dr_cnt <= (dr_cnt == CW'(TILE - 1)) ? '0 : dr_cnt + 1'b1;
        if (dr_cnt == CW'(TILE - 1)) ld_cnt <= '0;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> in_ready && !out_valid);

  assert_drain_after_full_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ld_cnt == CW'(TILE));

  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_lane_ok) && $stable(out_last));

  assert_last_position_R5: assert property (@(posedge clk) disable iff (rst)
    out_last == (out_valid && dr_cnt == CW'(TILE - 1)));

  assert_reload_after_drain_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> in_ready && !out_valid);

  for (genvar j = 0; j < TILE; j++) begin : g_lane
    assert_masked_zero_R7: assert property (@(posedge clk) disable iff (rst)
      !out_lane_ok[j] |-> out_row[j*DW +: DW] == '0);
  end
endmodule

bind tile_transposer tile_transposer_chk #(.TILE(TILE), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
  .out_lane_ok(out_lane_ok), .out_last(out_last)
);

// File: tb/tile_transposer_tb.sv
`timescale 1ns/1ps
module tile_transposer_tb;
  localparam int TILE = 16;
  localparam int DW   = 32;
  localparam int DIMW = 16;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [TILE*DW-1:0] in_row = '0;
  logic [DIMW-1:0] mat_width = '0, mat_height = '0, tile_col0 = '0, tile_row0 = '0;
  logic out_ready = 0;
  logic in_ready, out_valid, out_last;
  logic [TILE*DW-1:0] out_row;
  logic [TILE-1:0] out_lane_ok;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  tile_transposer #(.TILE(TILE), .DW(DW), .DIMW(DIMW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .mat_width(mat_width), .mat_height(mat_height), .tile_col0(tile_col0), .tile_row0(tile_row0),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_lane_ok(out_lane_ok), .out_last(out_last));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      fails = fails + 1;
      $display("FAIL watchdog R2: actual no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] word(input int t, input int r, input int c);
    return {8'(t), 8'(r), 8'(c), 8'hC3};
  endfunction

  task automatic chk(input string req, input logic [TILE*DW-1:0] act, input logic [TILE*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_tile(input int t, input int w, input int h, input int c0, input int r0,
                           input bit gaps, input int stop_after);
    for (int r = 0; r < TILE; r++) begin
      if (r == stop_after) return;
      @(negedge clk);
      if (gaps && (r % 3 == 1)) begin
        in_valid = 0;
        @(negedge clk);
      end
      for (int c = 0; c < TILE; c++) in_row[c*DW +: DW] = word(t, r, c);
      if (r == 0) begin
        mat_width = DIMW'(w); mat_height = DIMW'(h);
        tile_col0 = DIMW'(c0); tile_row0 = DIMW'(r0);
      end else begin
        // R8: bounds moved after the first row must be ignored
        mat_width = DIMW'(w + r); mat_height = 0;
        tile_col0 = 0; tile_row0 = DIMW'(r);
      end
      in_valid = 1;
    end
    @(negedge clk);
    in_valid = 0;
    // R2: after TILE rows the phase flips
    chk("R2", {in_ready, out_valid}, {1'b0, 1'b1});
  endtask

  task automatic drain_tile(input int t, input int w, input int h, input int c0, input int r0,
                            input bit stalls);
    int k = 0;
    int n = 0;
    while (k < TILE) begin
      logic [TILE*DW-1:0] ed;
      logic [TILE-1:0] eok;
      if (n > 0) @(negedge clk);
      n++;
      // R6: rows offered during the drain are refused
      in_valid = 1;
      for (int c = 0; c < TILE; c++) in_row[c*DW +: DW] = 32'hDEAD0000 | 32'(c);
      out_ready = !(stalls && (n % 3 == 0));
      for (int j = 0; j < TILE; j++) begin
        eok[j] = (longint'(r0) + j < longint'(h)) && (longint'(c0) + k < longint'(w));
        ed[j*DW +: DW] = eok[j] ? word(t, j, k) : '0;
      end
      chk("R3/R7 data", out_row, ed);
      chk("R7 lane mask", TILE*DW'(out_lane_ok), TILE*DW'(eok));
      chk("R5 last", TILE*DW'(out_last), TILE*DW'(k == TILE - 1));
      chk("R6 ready low", TILE*DW'({in_ready, out_valid}), TILE*DW'(2'b01));
      if (out_ready) k++;
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = 0;
    chk("R6 reload", TILE*DW'({in_ready, out_valid}), TILE*DW'(2'b10));
  endtask

  task automatic run_tile(input int t, input int w, input int h, input int c0, input int r0,
                          input bit noisy);
    load_tile(t, w, h, c0, r0, noisy, -1);
    drain_tile(t, w, h, c0, r0, noisy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset", TILE*DW'({in_ready, out_valid}), TILE*DW'(2'b10));

    run_tile(1, 16, 16, 0, 0, 0);                 // R3 full tile
    run_tile(2, 100, 100, 16, 32, 1);             // R4 stalls, offsets
    run_tile(3, 21, 9, 16, 0, 0);                 // R7 partial columns and rows, R9 after full
    run_tile(4, 0, 0, 0, 0, 1);                   // R7 all masked
    run_tile(5, 16'hFFFF, 16'hFFFF, 16'hFFF8, 16'hFFF0, 1); // R7 top of range
    run_tile(6, 40, 20, 32, 16, 0);               // R9 back to back
    run_tile(7, 3, 16, 0, 0, 1);

    // R1: reset in the middle of a load
    load_tile(8, 16, 16, 0, 0, 0, 5);
    @(negedge clk);
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 mid-load reset", TILE*DW'({in_ready, out_valid}), TILE*DW'(2'b10));
    run_tile(9, 16, 16, 0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule